// File: doc/BRIEF.md
# Partitioned All-Solutions Search Controller

This block coordinates a bank of independent N-Queens search engines to count every solution for one board size. The search space is cut by the row chosen for the queen in the first column: each such row is a self-contained sub-search. The block hands these rows out to the engines, starts every engine it can at once, and gives a freed engine the next unclaimed row as soon as it finishes. Each engine's partial count is added into a running total. The engines never share state and never wait on each other; the only place their work meets is that total.

A host reaches the block through two one-way byte ports, each with a valid/ack handshake. On the command port the host sends a board size and then a start code. When every row has been searched, the result port returns a completion flag byte followed by the total, least significant byte first. The block then waits for the next board size. The engines sit outside this block. Each one has a start pulse with a row index, and replies with a done pulse carrying its partial count.

Top module: `nq_partition_ctrl`

## Requirements
- R1: After reset, the command port acknowledges (ctl_ack_o high), the result port is idle (sts_valid_o low), and no engine start is asserted.
- R2: When the block waits for a size, a command byte from 1 to MAX_N (default 16) is taken as the board size. A byte of 0 or above MAX_N is consumed and ignored, and the block keeps waiting for a size.
- R3: Once a size is held, only the byte 0x01 starts a search; any other byte is consumed and ignored. From the start until the last result byte, ctl_ack_o stays low.
- R4: During one search, every row 0 to N-1 is issued exactly once through a one-cycle eng_start_o pulse, with the row index on that engine's eng_row_o slice (engine i uses bits i*ROW_W upward). Rows are issued in ascending order.
- R5: No row index equal to or above the board size is ever issued.
- R6: In the first dispatch cycle, all engines that can receive a row start together, min(NUM_ENG, N) of them. Lower engine indices receive lower rows, so engine i gets row i.
- R7: An engine whose done pulse has been taken receives the next unissued row, if one remains, two cycles later.
- R8: The total is the sum, modulo 2^32, of the counts of all accepted done pulses. A done pulse is accepted only from an engine that holds a row. A done pulse from an idle engine adds nothing.
- R9: After the last engine finishes, the result port sends five bytes under valid/ack: 0x01, then total bits 7:0, 15:8, 23:16, 31:24. A byte is held stable while valid is high and ack is low.
- R10: After the fifth result byte is taken, ctl_ack_o rises again and the block accepts a new board size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_data_i | input | 8 | Command byte from the host |
| ctl_valid_i | input | 1 | Command byte present |
| ctl_ack_o | output | 1 | Command byte taken in any cycle where it and ctl_valid_i are both high |
| sts_data_o | output | 8 | Result byte to the host |
| sts_valid_o | output | 1 | Result byte present |
| sts_ack_i | input | 1 | Host takes the result byte |
| eng_size_o | output | ROW_W | Board size shared by all engines |
| eng_start_o | output | NUM_ENG | One-cycle start pulse per engine |
| eng_row_o | output | NUM_ENG*ROW_W | First-column row per engine |
| eng_done_i | input | NUM_ENG | One-cycle done pulse per engine |
| eng_count_i | input | NUM_ENG*CNT_W | Partial count per engine, valid with done |

## Verification
The hardest case to reach from the ports is a done pulse from an engine that holds no row. The controller must drop it, yet it only matters while a real search is still summing. The engine models in the bench pick random latencies. After a real done pulse there is a single cycle in which that engine is idle before its refill start appears. The bench uses that gap to inject a bogus done with a large count in the middle of a search, and the returned total shows whether the count was added. Boards smaller than the engine bank and boards far larger than it, plus counts that wrap past 2^32, cover the rest of the dispatch and summing edges.

// File: rtl/nq_part_pkg.sv
package nq_part_pkg;
   typedef enum logic [1:0] {
      PH_IDLE,
      PH_RUN,
      PH_REPORT
   } phase_e;

   localparam logic [7:0] START_CODE = 8'h01;
   localparam logic [7:0] DONE_FLAG  = 8'h01;
endpackage

// File: rtl/nq_cmd_rx.sv
module nq_cmd_rx
   import nq_part_pkg::*;
#(
   parameter int MAX_N = 16,
   parameter int ROW_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       data_i,
   input  logic             valid_i,
   input  logic             open_i,
   output logic             ack_o,
   output logic [ROW_W-1:0] size_o,
   output logic             go_o
);
   logic             have_size_q;
   logic [ROW_W-1:0] size_q;
   logic             take;
   logic             size_ok;

   assign ack_o   = open_i;
   assign take    = valid_i & open_i;
   assign size_ok = (data_i != 8'd0) && (data_i <= 8'(MAX_N));
   assign go_o    = take & have_size_q & (data_i == START_CODE);
   assign size_o  = size_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         have_size_q <= 1'b0;
         size_q      <= '0;
      end else if (take) begin
         if (!have_size_q && size_ok) begin
            size_q      <= data_i[ROW_W-1:0];
            have_size_q <= 1'b1;
         end else if (go_o) begin
            have_size_q <= 1'b0;
         end
      end
   end

   // R2: a held size is always inside the legal range
   assert_size_range_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      have_size_q |-> (size_q != '0) && (int'(size_q) <= MAX_N));
endmodule

// File: rtl/nq_row_dispatch.sv
module nq_row_dispatch #(
   parameter int NUM_ENG = 3,
   parameter int ROW_W   = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     go_i,
   input  logic                     run_i,
   input  logic [ROW_W-1:0]         size_i,
   input  logic [NUM_ENG-1:0]       done_i,
   output logic [NUM_ENG-1:0]       start_o,
   output logic [NUM_ENG*ROW_W-1:0] row_o,
   output logic [NUM_ENG-1:0]       take_o,
   output logic                     fin_o
);
   logic [NUM_ENG-1:0] busy_q;
   logic [NUM_ENG-1:0] start_d, start_q;
   logic [ROW_W-1:0]   next_row_q;
   logic [ROW_W-1:0]   cursor;
   logic [ROW_W-1:0]   row_q [NUM_ENG];
   logic [ROW_W-1:0]   row_d [NUM_ENG];

   // lowest free engine gets the lowest pending row
   always_comb begin
      cursor  = next_row_q;
      start_d = '0;
      for (int i = 0; i < NUM_ENG; i++) begin
         row_d[i] = row_q[i];
         if (run_i && !busy_q[i] && (cursor < size_i)) begin
            start_d[i] = 1'b1;
            row_d[i]   = cursor;
            cursor     = cursor + 1'b1;
         end
      end
   end

   assign take_o = done_i & busy_q;
   assign fin_o  = run_i && (busy_q == '0) && (next_row_q == size_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= '0;
         start_q    <= '0;
         next_row_q <= '0;
      end else if (go_i) begin
         busy_q     <= '0;
         start_q    <= '0;
         next_row_q <= '0;
      end else begin
         busy_q     <= (busy_q & ~done_i) | start_d;
         start_q    <= start_d;
         next_row_q <= cursor;
      end
   end

   generate
      for (genvar g = 0; g < NUM_ENG; g++) begin : g_lane
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) row_q[g] <= '0;
            else        row_q[g] <= row_d[g];
         end
         assign start_o[g]                   = start_q[g];
         assign row_o[g*ROW_W +: ROW_W]      = row_q[g];

         // R5: an issued row is always inside the board
         assert_row_bound_R5 : assert property (@(posedge clk) disable iff (!rst_n)
            start_o[g] |-> (row_q[g] < size_i));
      end
   endgenerate

   // R4: the row cursor never moves backwards within a search
   assert_cursor_mono_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      run_i |=> (!run_i || (next_row_q >= $past(next_row_q))));
endmodule

// File: rtl/nq_sum_accum.sv
module nq_sum_accum #(
   parameter int NUM_ENG = 3,
   parameter int CNT_W   = 32
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_i,
   input  logic [NUM_ENG-1:0]       add_en_i,
   input  logic [NUM_ENG*CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0]         total_o
);
   logic [CNT_W-1:0] total_q;
   logic [CNT_W-1:0] inc;

   generate
      if (NUM_ENG == 1) begin : g_single
         assign inc = add_en_i[0] ? cnt_i : '0;
      end else begin : g_multi
         logic [CNT_W-1:0] part [NUM_ENG];
         for (genvar g = 0; g < NUM_ENG; g++) begin : g_gate
            assign part[g] = add_en_i[g] ? cnt_i[g*CNT_W +: CNT_W] : '0;
         end
         always_comb begin
            inc = '0;
            for (int i = 0; i < NUM_ENG; i++) inc = inc + part[i];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     total_q <= '0;
      else if (clr_i) total_q <= '0;
      else            total_q <= total_q + inc;
   end

   assign total_o = total_q;

   // R8: the total only moves when some engine's done is taken
   assert_total_hold_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && (add_en_i == '0)) |=> $stable(total_q));
endmodule

// File: rtl/nq_sts_tx.sv
module nq_sts_tx
   import nq_part_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] total_i,
   input  logic             ack_i,
   output logic [7:0]       data_o,
   output logic             valid_o,
   output logic             last_o
);
   localparam int NBYTES = CNT_W / 8;
   localparam int IDX_W  = $clog2(NBYTES + 1);

   logic             active_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] shadow_q;
   logic             xfer;

   assign xfer    = active_q & ack_i;
   assign valid_o = active_q;
   assign data_o  = (idx_q == '0) ? DONE_FLAG : shadow_q[7:0];
   assign last_o  = xfer && (idx_q == IDX_W'(NBYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         idx_q    <= '0;
         shadow_q <= '0;
      end else if (load_i) begin
         active_q <= 1'b1;
         idx_q    <= '0;
         shadow_q <= total_i;
      end else if (xfer) begin
         if (last_o) active_q <= 1'b0;
         idx_q <= idx_q + 1'b1;
         if (idx_q != '0) shadow_q <= shadow_q >> 8;
      end
   end

   // R9: an offered byte is held until the host takes it
   assert_byte_hold_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !ack_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/nq_partition_ctrl.sv
module nq_partition_ctrl
   import nq_part_pkg::*;
#(
   parameter int NUM_ENG = 3,
   parameter int MAX_N   = 16,
   parameter int CNT_W   = 32,
   localparam int ROW_W  = $clog2(MAX_N + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [7:0]               ctl_data_i,
   input  logic                     ctl_valid_i,
   output logic                     ctl_ack_o,
   output logic [7:0]               sts_data_o,
   output logic                     sts_valid_o,
   input  logic                     sts_ack_i,
   output logic [ROW_W-1:0]         eng_size_o,
   output logic [NUM_ENG-1:0]       eng_start_o,
   output logic [NUM_ENG*ROW_W-1:0] eng_row_o,
   input  logic [NUM_ENG-1:0]       eng_done_i,
   input  logic [NUM_ENG*CNT_W-1:0] eng_count_i
);
   generate
      if (NUM_ENG < 1) begin : g_bad_eng
         $error("NUM_ENG must be at least 1");
      end
      if (MAX_N < 1 || MAX_N > 255 || ROW_W > 8) begin : g_bad_size
         $error("MAX_N must lie in 1..255");
      end
      if (CNT_W < 8 || (CNT_W % 8) != 0) begin : g_bad_cnt
         $error("CNT_W must be a whole number of bytes");
      end
   endgenerate

   phase_e                   phase_q;
   logic                     go, fin, last;
   logic [NUM_ENG-1:0]       take;
   logic [CNT_W-1:0]         total;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else begin
         unique case (phase_q)
            PH_IDLE:   if (go)   phase_q <= PH_RUN;
            PH_RUN:    if (fin)  phase_q <= PH_REPORT;
            PH_REPORT: if (last) phase_q <= PH_IDLE;
            default:             phase_q <= PH_IDLE;
         endcase
      end
   end

   nq_cmd_rx #(.MAX_N(MAX_N), .ROW_W(ROW_W)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_i  (ctl_data_i),
      .valid_i (ctl_valid_i),
      .open_i  (phase_q == PH_IDLE),
      .ack_o   (ctl_ack_o),
      .size_o  (eng_size_o),
      .go_o    (go)
   );

   nq_row_dispatch #(.NUM_ENG(NUM_ENG), .ROW_W(ROW_W)) u_disp (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (go),
      .run_i   (phase_q == PH_RUN),
      .size_i  (eng_size_o),
      .done_i  (eng_done_i),
      .start_o (eng_start_o),
      .row_o   (eng_row_o),
      .take_o  (take),
      .fin_o   (fin)
   );

   nq_sum_accum #(.NUM_ENG(NUM_ENG), .CNT_W(CNT_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (go),
      .add_en_i (take),
      .cnt_i    (eng_count_i),
      .total_o  (total)
   );

   nq_sts_tx #(.CNT_W(CNT_W)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (fin),
      .total_i (total),
      .ack_i   (sts_ack_i),
      .data_o  (sts_data_o),
      .valid_o (sts_valid_o),
      .last_o  (last)
   );

   // R3: the command port is closed whenever engines are being launched
   assert_closed_in_run_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (eng_start_o != '0) |-> !ctl_ack_o);

   // R9: result bytes are never offered while the command port is open
   assert_no_report_idle_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      sts_valid_o |-> !ctl_ack_o);
endmodule

// File: tb/test_nq_partition_ctrl.sv
module test_nq_partition_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_ENG    = 3;
   localparam int MAX_N      = 16;
   localparam int CNT_W      = 32;
   localparam int ROW_W      = $clog2(MAX_N + 1);

   logic                     clk = 1'b0;
   logic                     rst_n = 1'b0;
   logic [7:0]               ctl_data = '0;
   logic                     ctl_valid = 1'b0;
   logic                     ctl_ack;
   logic [7:0]               sts_data;
   logic                     sts_valid;
   logic                     sts_ack = 1'b0;
   logic [ROW_W-1:0]         eng_size;
   logic [NUM_ENG-1:0]       eng_start;
   logic [NUM_ENG*ROW_W-1:0] eng_row;
   logic [NUM_ENG-1:0]       eng_done = '0;
   logic [NUM_ENG*CNT_W-1:0] eng_count = '0;

   int n_checks = 0;
   int n_fail   = 0;

   logic [7:0] exp_q[$];
   int  hits [32];
   int  m_timer [NUM_ENG];
   bit  m_busy [NUM_ENG];
   int  m_row [NUM_ENG];
   int  run_size = 0;
   bit  first_pending = 1'b0;
   int  first_pop = 0;
   bit  first_order_ok = 1'b1;
   bit  stray_req = 1'b0;
   int  stray_fired = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nq_partition_ctrl #(.NUM_ENG(NUM_ENG), .MAX_N(MAX_N), .CNT_W(CNT_W)) i_nq_partition_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_data_i  (ctl_data),
      .ctl_valid_i (ctl_valid),
      .ctl_ack_o   (ctl_ack),
      .sts_data_o  (sts_data),
      .sts_valid_o (sts_valid),
      .sts_ack_i   (sts_ack),
      .eng_size_o  (eng_size),
      .eng_start_o (eng_start),
      .eng_row_o   (eng_row),
      .eng_done_i  (eng_done),
      .eng_count_i (eng_count)
   );

   function automatic logic [31:0] cnt_of(int n, int r);
      if (n == 10) return 32'h3000_0000 + 32'(r);
      return 32'(r * r + (r + 1) * (n + 3) + 7);
   endfunction

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // engine models: sampled and driven on the falling edge
   initial begin
      for (int i = 0; i < NUM_ENG; i++) begin
         m_busy[i] = 1'b0; m_timer[i] = 0; m_row[i] = 0;
      end
      forever begin
         @(negedge clk);
         if (first_pending && (eng_start != '0)) begin
            first_pending = 1'b0;
            first_pop     = $countones(eng_start);
            for (int i = 0; i < NUM_ENG; i++)
               if (eng_start[i] && (int'(eng_row[i*ROW_W +: ROW_W]) != i)) first_order_ok = 1'b0;
         end
         for (int i = 0; i < NUM_ENG; i++) begin
            eng_done[i] = 1'b0;
            if (eng_start[i]) begin
               m_busy[i]  = 1'b1;
               m_row[i]   = int'(eng_row[i*ROW_W +: ROW_W]);
               m_timer[i] = int'($urandom_range(1, 6));
               hits[m_row[i]]++;
            end else if (m_busy[i]) begin
               m_timer[i]--;
               if (m_timer[i] == 0) begin
                  m_busy[i] = 1'b0;
                  eng_done[i] = 1'b1;
                  eng_count[i*CNT_W +: CNT_W] = cnt_of(run_size, m_row[i]);
               end
            end else if (stray_req && i == 0) begin
               stray_req = 1'b0;
               stray_fired++;
               eng_done[i] = 1'b1;
               eng_count[i*CNT_W +: CNT_W] = 32'h0BAD_0000;
            end
         end
      end
   end

   // scoreboard monitor on the result port
   initial begin
      forever begin
         @(negedge clk);
         if (sts_ack) sts_ack = 1'b0;
         else if (sts_valid && $urandom_range(0, 2) == 0) begin
            if (exp_q.size() == 0) chk(1'b0, "R9 unexpected byte", sts_data, 0);
            else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               chk(sts_data == e, "R8 R9 result byte", sts_data, e);
            end
            sts_ack = 1'b1;
         end
      end
   end

   // watchdog
   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      ctl_data  = b;
      ctl_valid = 1'b1;
      while (!ctl_ack) @(negedge clk);
      @(negedge clk);
      ctl_valid = 1'b0;
   endtask

   task automatic prepare(input int n);
      logic [31:0] sum;
      sum = '0;
      for (int r = 0; r < 32; r++) hits[r] = 0;
      for (int r = 0; r < n; r++) sum = sum + cnt_of(n, r);
      run_size       = n;
      first_pending  = 1'b1;
      first_order_ok = 1'b1;
      exp_q.push_back(8'h01);
      for (int b = 0; b < 4; b++) exp_q.push_back(sum[8*b +: 8]);
   endtask

   task automatic finish_run(input int n);
      int exp_pop;
      while (exp_q.size() != 0 || sts_valid) @(negedge clk);
      @(negedge clk);
      chk(ctl_ack == 1'b1, "R10 command port reopens", ctl_ack, 1);
      for (int r = 0; r < 32; r++) begin
         if (r < n) chk(hits[r] == 1, "R4 R7 row issued once", hits[r], 1);
         else if (r < MAX_N + 2) chk(hits[r] == 0, "R5 row beyond board", hits[r], 0);
      end
      exp_pop = (n < NUM_ENG) ? n : NUM_ENG;
      chk(first_pop == exp_pop, "R6 first launch width", first_pop, exp_pop);
      chk(first_order_ok, "R6 engine i gets row i", first_order_ok, 1);
   endtask

   task automatic run_search(input int n, input bit stray);
      prepare(n);
      send(8'(n));
      send(8'h01);
      if (stray) stray_req = 1'b1;
      @(negedge clk);
      chk(ctl_ack == 1'b0, "R3 port closed while searching", ctl_ack, 0);
      finish_run(n);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ctl_ack == 1'b1, "R1 ack after reset", ctl_ack, 1);
      chk(sts_valid == 1'b0, "R1 result idle after reset", sts_valid, 0);
      chk(eng_start == '0, "R1 no start after reset", eng_start, 0);

      run_search(4, 1'b0);
      run_search(1, 1'b0);
      // R8: stray done from an idle engine mid-search must not count
      run_search(8, 1'b1);
      chk(stray_fired == 1, "R8 stray done injected", stray_fired, 1);

      // R2 and R3: illegal sizes and a wrong start byte are dropped
      prepare(6);
      send(8'd0);
      send(8'd17);
      send(8'd6);
      send(8'h55);
      begin
         int seen;
         seen = 0;
         repeat (10) begin
            @(negedge clk);
            if (eng_start != '0) seen++;
         end
         chk(seen == 0, "R3 non-start byte ignored", seen, 0);
      end
      chk(ctl_ack == 1'b1, "R2 still accepting", ctl_ack, 1);
      send(8'h01);
      finish_run(6);

      // R8: the total wraps modulo 2^32
      run_search(10, 1'b0);
      run_search(MAX_N, 1'b0);

      repeat (5) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule